// File: doc/BRIEF.md
# Chained Block Descriptor Sequencer

This block walks a linked list of DMA block descriptors in memory for a single channel. Each descriptor takes seven 32-bit words. Given a start address, the sequencer reads the five words the channel needs, one word per access. These are the source address, the destination address, the next-item pointer and the two control words. It presents them to the data mover and starts the block with a one-cycle pulse.

When the data mover reports that the block is finished, the sequencer writes the data mover's updated control-high word back into the descriptor, with the done flag set. It then either follows the next-item pointer or ends the transfer. Chaining can be enabled from the source side, from the destination side, or from both. The two status words at the end of each descriptor are left untouched.

Memory is reached through a single-word request/acknowledge port. A parameter selects whether descriptor words in memory are stored little- or big-endian.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `memReq`, `blkStart` and `xferDone` are all low.
- R2: A `startReq` pulse while idle starts a fetch at `startAddr` with its two lowest bits cleared.
- R3: Each descriptor is read in the order offset 0, 4, 8, 12, 16, with exactly one read per word. While `memReq` is high and `memAck` is low, the address and direction hold steady.
- R4: Only after all five words are loaded does `blkStart` pulse for one cycle. At that point the channel outputs carry word 0 (source), word 1 (destination), word 2 (next pointer), word 3 (control low) and word 4 (control high).
- R5: With `BIG_ENDIAN`=1, every word is byte-reversed between memory and the channel side, on both read and writeback. With `BIG_ENDIAN`=0 words pass unchanged.
- R6: After `blkDone`, the sequencer writes `blkCtlHiUpd` with bit 12 (done) forced to one to descriptor offset 16. This write comes before any read of a following descriptor.
- R7: No memory word other than offset 16 of each visited descriptor is ever written; the status words at offsets 20 and 24 and the four leading words are preserved.
- R8: The chain continues when control-low bit 28 (source chaining) or bit 27 (destination chaining) is set and the next pointer with its two lowest bits cleared is nonzero. The next descriptor is fetched from that cleared address.
- R9: When the chain does not continue, `xferDone` pulses for one cycle after the writeback is acknowledged, and the block returns to idle in the next cycle.
- R10: A `startReq` that arrives while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a chain walk (taken only when idle) |
| startAddr | input | AW | Address of the first descriptor |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Byte address of the word accessed |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with `memAck` |
| memAck | input | 1 | Access completed this cycle |
| chSrcAddr | output | 32 | Source address of the current block |
| chDstAddr | output | 32 | Destination address of the current block |
| chNextPtr | output | 32 | Next-item pointer of the current block |
| chCtlLo | output | 32 | Control-low word of the current block |
| chCtlHi | output | 32 | Control-high word (size in bits 11:0) |
| blkStart | output | 1 | One-cycle pulse: block is ready to move |
| blkDone | input | 1 | Data mover finished the block |
| blkCtlHiUpd | input | 32 | Updated control-high value, sampled with `blkDone` |
| busy | output | 1 | A chain walk is in progress |
| xferDone | output | 1 | One-cycle pulse when the chain has ended |

## Verification
The bench builds the block with `BIG_ENDIAN`=1 and a 12-bit address width. The byte-reversal path is therefore active on every read and every writeback, and an error in lane order shows up in both the channel outputs and the stored control word. The narrow address space lets chains of up to six descriptors sit in a 4 KB bench memory at scattered slots. It also means garbage in the low two pointer bits and nonzero pointers that must not be followed can be set up directly. Memory acknowledge latency is random, so the hold-until-acknowledge behaviour is exercised on every access.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  localparam int WORDS_LOADED  = 5;   // source, dest, next, ctl low, ctl high
  localparam int IDX_W         = 3;
  localparam int WB_IDX        = 4;   // control-high word index
  localparam int DONE_BIT      = 12;
  localparam int CHAIN_SRC_BIT = 28;
  localparam int CHAIN_DST_BIT = 27;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LAUNCH,
    ST_BLOCK,
    ST_WRBACK,
    ST_END
  } seqState_t;

  typedef struct packed {
    logic loadBase;  // capture start address
    logic loadWord;  // capture read word at current index
    logic capUpd;    // capture updated control-high word
    logic follow;    // move base to next pointer
  } dpStrobe_t;

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/dcw_ctrl.sv
module dcw_ctrl
  import dcw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             memAck,
  input  logic             blkDone,
  input  logic             chainGo,
  output dpStrobe_t        strb,
  output logic [IDX_W-1:0] wordIdx,
  output logic             memReq,
  output logic             memWe,
  output logic             blkStart,
  output logic             xferDone,
  output logic             busy
);

  seqState_t        state, stateNxt;
  logic [IDX_W-1:0] idxNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else begin
      state   <= stateNxt;
      wordIdx <= idxNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    idxNxt   = wordIdx;
    strb     = '0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    blkStart = 1'b0;
    xferDone = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.loadBase = 1'b1;
          idxNxt        = '0;
          stateNxt      = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.loadWord = 1'b1;
          if (wordIdx == IDX_W'(WB_IDX)) stateNxt = ST_LAUNCH;
          else                           idxNxt   = wordIdx + 1'b1;
        end
      end
      ST_LAUNCH: begin
        blkStart = 1'b1;
        stateNxt = ST_BLOCK;
      end
      ST_BLOCK: begin
        if (blkDone) begin
          strb.capUpd = 1'b1;
          idxNxt      = IDX_W'(WB_IDX);
          stateNxt    = ST_WRBACK;
        end
      end
      ST_WRBACK: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          if (chainGo) begin
            strb.follow = 1'b1;
            idxNxt      = '0;
            stateNxt    = ST_FETCH;
          end else begin
            stateNxt = ST_END;
          end
        end
      end
      ST_END: begin
        xferDone = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/dcw_datapath.sv
module dcw_datapath
  import dcw_pkg::*;
#(
  parameter int AW         = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic [AW-1:0]    startAddr,
  input  logic [31:0]      memRdata,
  input  logic [31:0]      blkCtlHiUpd,
  output logic [AW-1:0]    memAddr,
  output logic [31:0]      memWdata,
  output logic [31:0]      chSrcAddr,
  output logic [31:0]      chDstAddr,
  output logic [31:0]      chNextPtr,
  output logic [31:0]      chCtlLo,
  output logic [31:0]      chCtlHi,
  output logic             chainGo
);

  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

  logic [AW-1:0] descBase;
  logic [31:0]   words [WORDS_LOADED];
  logic [31:0]   updWord;
  logic [31:0]   rdFix;
  logic [31:0]   wbLogical;

  assign wbLogical = updWord | (32'd1 << DONE_BIT);

  // Byte-lane order between memory and channel side
  if (BIG_ENDIAN) begin : g_be
    assign rdFix    = swap32(memRdata);
    assign memWdata = swap32(wbLogical);
  end else begin : g_le
    assign rdFix    = memRdata;
    assign memWdata = wbLogical;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descBase <= '0;
      updWord  <= '0;
    end else begin
      if (strb.loadBase) descBase <= startAddr & ALIGN_MASK;
      else if (strb.follow) descBase <= words[2][AW-1:0] & ALIGN_MASK;
      if (strb.capUpd) updWord <= blkCtlHiUpd;
    end
  end

  for (genvar g = 0; g < WORDS_LOADED; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) words[g] <= '0;
      else if (strb.loadWord && wordIdx == IDX_W'(g)) words[g] <= rdFix;
    end
  end

  assign memAddr   = descBase + AW'({wordIdx, 2'b00});
  assign chSrcAddr = words[0];
  assign chDstAddr = words[1];
  assign chNextPtr = words[2];
  assign chCtlLo   = words[3];
  assign chCtlHi   = words[WB_IDX];

  assign chainGo = (words[3][CHAIN_SRC_BIT] | words[3][CHAIN_DST_BIT])
                   && ((words[2][AW-1:0] & ALIGN_MASK) != '0);

endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
  import dcw_pkg::*;
#(
  parameter int AW         = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic [AW-1:0] startAddr,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  input  logic          memAck,
  output logic [31:0]   chSrcAddr,
  output logic [31:0]   chDstAddr,
  output logic [31:0]   chNextPtr,
  output logic [31:0]   chCtlLo,
  output logic [31:0]   chCtlHi,
  output logic          blkStart,
  input  logic          blkDone,
  input  logic [31:0]   blkCtlHiUpd,
  output logic          busy,
  output logic          xferDone
);

  dpStrobe_t        strb;
  logic [IDX_W-1:0] wordIdx;
  logic             chainGo;

  dcw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .memAck   (memAck),
    .blkDone  (blkDone),
    .chainGo  (chainGo),
    .strb     (strb),
    .wordIdx  (wordIdx),
    .memReq   (memReq),
    .memWe    (memWe),
    .blkStart (blkStart),
    .xferDone (xferDone),
    .busy     (busy)
  );

  dcw_datapath #(.AW(AW), .BIG_ENDIAN(BIG_ENDIAN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wordIdx     (wordIdx),
    .startAddr   (startAddr),
    .memRdata    (memRdata),
    .blkCtlHiUpd (blkCtlHiUpd),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .chSrcAddr   (chSrcAddr),
    .chDstAddr   (chDstAddr),
    .chNextPtr   (chNextPtr),
    .chCtlLo     (chCtlLo),
    .chCtlHi     (chCtlHi),
    .chainGo     (chainGo)
  );

endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          memReq,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic          memAck,
  input logic          wbFlag,
  input logic          blkStart,
  input logic          xferDone,
  input logic          busy
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !blkStart && !xferDone)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R3

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00)); // R8

  AST_BLK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    blkStart |=> !blkStart); // R4

  AST_WB_DONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> wbFlag); // R6

  AST_XFER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> (!xferDone && !busy)); // R9

endmodule

bind desc_chain_walker dcw_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memAck   (memAck),
  .wbFlag   (BIG_ENDIAN ? memWdata[20] : memWdata[12]),
  .blkStart (blkStart),
  .xferDone (xferDone),
  .busy     (busy)
);

// File: tb/sim_desc_chain_walker.sv
module sim_desc_chain_walker;

  localparam int PERIOD = 10;
  localparam int AW     = 12;
  localparam bit BE     = 1'b1;
  localparam int MAXD   = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic          memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [31:0]   memWdata;
  logic [31:0]   memRdata = '0;
  logic          memAck = 1'b0;
  logic [31:0]   chSrcAddr, chDstAddr, chNextPtr, chCtlLo, chCtlHi;
  logic          blkStart, busy, xferDone;
  logic          blkDone = 1'b0;
  logic [31:0]   blkCtlHiUpd = '0;

  int checks = 0;
  int failures = 0;

  logic [31:0] mem [1024];
  logic        logWe   [1024];
  logic [AW-1:0] logAddr [1024];
  int logN = 0;
  int blkCnt = 0;
  int xferCnt = 0;

  // expected descriptors, logical values
  logic [31:0] dWord [MAXD][7];
  logic [31:0] dUpd  [MAXD];
  int          dAddr [MAXD];

  always #(PERIOD/2) clk = ~clk;

  desc_chain_walker #(.AW(AW), .BIG_ENDIAN(BE)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck),
    .chSrcAddr(chSrcAddr), .chDstAddr(chDstAddr), .chNextPtr(chNextPtr),
    .chCtlLo(chCtlLo), .chCtlHi(chCtlHi), .blkStart(blkStart),
    .blkDone(blkDone), .blkCtlHiUpd(blkCtlHiUpd), .busy(busy), .xferDone(xferDone)
  );

  function automatic logic [31:0] toMem(input logic [31:0] v);
    if (BE) return {v[7:0], v[15:8], v[23:16], v[31:24]};
    return v;
  endfunction

  // memory model with random acknowledge latency
  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck && ($urandom % 3 != 0)) begin
        memAck <= 1'b1;
        if (memWe) mem[memAddr[AW-1:2]] <= memWdata;
        else       memRdata <= mem[memAddr[AW-1:2]];
        logWe[logN]   <= memWe;
        logAddr[logN] <= memAddr;
        logN <= logN + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rstN && blkStart) blkCnt <= blkCnt + 1;
    if (rstN && xferDone) xferCnt <= xferCnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic waitFor(input int which);
    @(negedge clk);
    while (which == 0 ? !blkStart : !xferDone) @(negedge clk);
  endtask

  // endMode 0: last has chain bits set but zero pointer; 1: no chain bits, nonzero pointer
  task automatic runChain(input int n, input int endMode);
    int logBase, blkBase, xferBase, off;
    off = $urandom % 120;
    for (int i = 0; i < n; i++) dAddr[i] = (((i * 37 + off) % 120) + 1) * 32;
    for (int i = 0; i < n; i++) begin
      logic [31:0] lo;
      int cm;
      for (int w = 0; w < 7; w++) dWord[i][w] = $urandom;
      lo = $urandom & ~32'h1800_0000;
      cm = $urandom % 3;
      if (i < n - 1 || endMode == 0)
        lo = lo | (cm == 0 ? 32'h1000_0000 : cm == 1 ? 32'h0800_0000 : 32'h1800_0000);
      dWord[i][3] = lo;
      if (i < n - 1)        dWord[i][2] = dAddr[i+1] | ($urandom % 4);
      else if (endMode == 0) dWord[i][2] = $urandom % 4;
      else                   dWord[i][2] = 32'd4064 | ($urandom % 4);
      dUpd[i] = $urandom & ~32'h0000_1000;
      for (int w = 0; w < 7; w++) mem[(dAddr[i] >> 2) + w] = toMem(dWord[i][w]);
    end
    logBase = logN; blkBase = blkCnt; xferBase = xferCnt;
    @(negedge clk);
    startReq = 1'b1; startAddr = AW'(dAddr[0] | ($urandom % 4));
    @(negedge clk);
    startReq = 1'b0;
    for (int i = 0; i < n; i++) begin
      waitFor(0);
      check(chSrcAddr == dWord[i][0] && chDstAddr == dWord[i][1], "R4 R5",
            "src/dst at block start", chSrcAddr ^ chDstAddr, dWord[i][0] ^ dWord[i][1]);
      check(chNextPtr == dWord[i][2] && chCtlLo == dWord[i][3] && chCtlHi == dWord[i][4],
            "R4 R5", "next/ctl at block start", chCtlHi, dWord[i][4]);
      if (i == 0) begin
        @(negedge clk);
        startReq = 1'b1; startAddr = AW'(4000);  // R10: must be ignored
        @(negedge clk);
        startReq = 1'b0;
      end
      repeat ($urandom % 5) @(negedge clk);
      @(negedge clk);
      blkDone = 1'b1; blkCtlHiUpd = dUpd[i];
      @(negedge clk);
      blkDone = 1'b0;
    end
    waitFor(1);
    @(negedge clk);
    check(!busy, "R9", "idle after transfer done", 32'(busy), 32'd0);
    check(xferCnt - xferBase == 1, "R9", "transfer done pulses", xferCnt - xferBase, 1);
    check(blkCnt - blkBase == n, "R8", "blocks launched", blkCnt - blkBase, n);
    check(logN - logBase == 6 * n, "R3 R10", "memory access count", logN - logBase, 6 * n);
    for (int i = 0; i < n; i++) begin
      bit ok = 1'b1;
      for (int k = 0; k < 5; k++)
        if (logWe[logBase + 6*i + k] !== 1'b0 || logAddr[logBase + 6*i + k] != AW'(dAddr[i] + 4*k))
          ok = 1'b0;
      check(ok, i == 0 ? "R2 R3" : "R3 R8", "read sequence of descriptor",
            32'(logAddr[logBase + 6*i]), dAddr[i]);
      check(logWe[logBase + 6*i + 5] === 1'b1 && logAddr[logBase + 6*i + 5] == AW'(dAddr[i] + 16),
            "R6", "writeback position", 32'(logAddr[logBase + 6*i + 5]), dAddr[i] + 16);
      check(mem[(dAddr[i] >> 2) + 4] == toMem(dUpd[i] | 32'h1000), "R6 R5",
            "stored control high", mem[(dAddr[i] >> 2) + 4], toMem(dUpd[i] | 32'h1000));
      ok = 1'b1;
      for (int w = 0; w < 7; w++)
        if (w != 4 && mem[(dAddr[i] >> 2) + w] != toMem(dWord[i][w])) ok = 1'b0;
      check(ok, "R7", "untouched descriptor words", mem[(dAddr[i] >> 2) + 5], toMem(dWord[i][5]));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    check(!busy && !memReq && !blkStart && !xferDone, "R1", "reset state",
          {28'd0, busy, memReq, blkStart, xferDone}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memReq, "R1", "idle after reset release", {30'd0, busy, memReq}, 32'd0);
    runChain(1, 0);
    runChain(1, 1);
    runChain(4, 0);
    runChain(3, 1);
    for (int r = 0; r < 10; r++) runChain(1 + ($urandom % 6), $urandom % 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog run did not complete actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule